// File: doc/BRIEF.md
# 64-bit Global Timer with Comparator

This block is a free-running 64-bit up-counter that software reaches through a small 32-bit register bus. The counter advances once every `prescaler + 1` clock cycles while the run bit is set. Both halves of the counter are loaded from the bus, but only while the timer is stopped. When the counter is read while it runs, software reads the upper half, then the lower half, then the upper half again, and repeats the sequence if the two upper values differ. The hardware always increments all 64 bits together on one tick.

A 64-bit comparator is loaded through two 32-bit registers. While compare is enabled and the counter is at or above the comparator, a compare event occurs. Each event sets a sticky status flag, which software clears by writing a one to it. When auto-increment is enabled, each event also adds a programmable 32-bit step to the comparator. This gives a periodic interrupt without ever stopping or resetting the counter. The interrupt output is the status flag gated by the interrupt enable bit.

Bus writes take effect on the clock edge that samples the write strobe. Read data appears on the edge after the read strobe and holds until the next read. Registers live at byte offsets 0x00 (counter low), 0x04 (counter high), 0x08 (control), 0x0C (status), 0x10 (comparator low), 0x14 (comparator high) and 0x18 (step). Any other address reads as zero and ignores writes.

Top module: `gtmr_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Control bit 0 (run) makes the counter advance by one every `P+1` clock cycles, where `P` is control bits 15:8. The prescale phase restarts from zero when run is set. With run clear, the counter holds its value.
- R3: The counter increments as one 64-bit value. When the lower half rolls over from all ones to zero, the upper half increments on the same tick.
- R4: Writes to offsets 0x00 and 0x04 load the matching counter half while run is clear, and have no effect while run is set.
- R5: While control bit 1 (compare enable) is set and the counter is greater than or equal to the comparator, status bit 0 becomes set on the next edge. This also holds when the comparator is already in the past at the moment compare is enabled.
- R6: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged.
- R7: `irq` is high exactly when status bit 0 and control bit 2 (interrupt enable) are both set.
- R8: With control bit 3 (auto-increment) set, each compare event adds the step register at 0x18 to the full 64-bit comparator. The carry propagates into the upper comparator half, and the sum can be read back at 0x10 and 0x14.
- R9: With compare enable clear, no compare event occurs, whatever the counter and comparator values are.
- R10: `bus_rdata` carries the addressed register one cycle after `bus_rd` and holds that value while `bus_rd` is low. Control reads back as written, in bits 0 to 3 and 15:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt: event flag AND interrupt enable |

## Verification
A wrong prescale phase or a missed carry shows up as a counter read that is off by one or more. The value of every read is predicted from the exact edge on which it is sampled, so the error is caught on the first read after the faulty tick. A faulty comparator update shows up in the comparator readback at 0x10 and 0x14 one read after the event, and a flag that is set, stuck or cleared wrongly shows in the status read and on `irq` within one cycle. A missing carry between the comparator halves is exposed by a step that crosses the 32-bit boundary.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

  // Byte offsets on the register bus.
  localparam int OFS_CNT  = 'h00;  // counter halves at +0, +4
  localparam int OFS_CTRL = 'h08;
  localparam int OFS_STAT = 'h0C;
  localparam int OFS_CMP  = 'h10;  // comparator halves at +0, +4
  localparam int OFS_STEP = 'h18;

  // Control field positions.
  localparam int CB_RUN  = 0;
  localparam int CB_CMP  = 1;
  localparam int CB_IRQ  = 2;
  localparam int CB_AUTO = 3;
  localparam int PS_LSB  = 8;
  localparam int PS_W    = 8;

  typedef struct packed {
    logic [PS_W-1:0] presc;
    logic            auto_en;
    logic            irq_en;
    logic            cmp_en;
    logic            run;
  } ctrl_t;

endpackage

// File: rtl/gtmr_prescale.sv
module gtmr_prescale #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] presc,
  output logic            tick
);

  logic [PS_W-1:0] phase_q;

  assign tick = run && (phase_q == presc);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PS_W'(1);
    end
  end

  // R2: with a nonzero divider two ticks are never adjacent
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && presc != '0) |=> (!tick || presc == '0));

endmodule

// File: rtl/gtmr_count.sv
module gtmr_count #(
  parameter int CNT_W = 64,
  parameter int BUS_W = 32,
  localparam int NH   = CNT_W / BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [NH-1:0]    ld,
  input  logic [BUS_W-1:0] ld_data,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = tick ? cnt_q + CNT_W'(1) : cnt_q;
    for (int h = 0; h < NH; h++) begin
      if (ld[h]) cnt_d[h*BUS_W +: BUS_W] = ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3: a tick moves the whole 64-bit value by exactly one
  a_r3_atomic_step: assert property (@(posedge clk) disable iff (rst)
    (tick && ld == '0) |=> cnt == $past(cnt) + CNT_W'(1));

  // R2: without tick or load the counter is frozen
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && ld == '0) |=> $stable(cnt));

  // R4: a lower-half load lands as written
  a_r4_load_low: assert property (@(posedge clk) disable iff (rst)
    ld[0] |=> cnt[BUS_W-1:0] == $past(ld_data));

endmodule

// File: rtl/gtmr_compare.sv
module gtmr_compare #(
  parameter int CNT_W = 64,
  parameter int BUS_W = 32,
  localparam int NH   = CNT_W / BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cmp_en,
  input  logic             auto_en,
  input  logic [NH-1:0]    cmp_wr,
  input  logic             step_wr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             clr,
  output logic [CNT_W-1:0] cmp,
  output logic [BUS_W-1:0] step,
  output logic             flag
);

  logic [CNT_W-1:0] cmp_q;
  logic [BUS_W-1:0] step_q;
  logic             flag_q;
  logic             hit;

  assign hit = cmp_en && (cnt >= cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      step_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (hit && auto_en) cmp_q <= cmp_q + CNT_W'(step_q);
      for (int h = 0; h < NH; h++) begin
        if (cmp_wr[h]) cmp_q[h*BUS_W +: BUS_W] <= wdata;
      end
      if (step_wr) step_q <= wdata;
      flag_q <= hit | (flag_q & ~clr);
    end
  end

  assign cmp  = cmp_q;
  assign step = step_q;
  assign flag = flag_q;

  // R8: an event under auto-increment advances the comparator by the step
  a_r8_auto_step: assert property (@(posedge clk) disable iff (rst)
    (hit && auto_en && cmp_wr == '0) |=> cmp == $past(cmp) + CNT_W'($past(step)));

  // R6: the flag only drops on a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  // R9: no flag can appear while compare is disabled
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (!cmp_en && !flag) |=> !flag);

endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
  import gtmr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int BUS_W = 32,
  parameter int AW    = 5,
  localparam int NH   = CNT_W / BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic             bus_rd,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq
);

  ctrl_t            ctrl_q;
  logic             tick;
  logic [NH-1:0]    cnt_wr, cmp_wr;
  logic [CNT_W-1:0] cnt, cmp;
  logic [BUS_W-1:0] step;
  logic             flag;
  logic             ctrl_wr, stat_wr, step_wr, clr;
  logic [BUS_W-1:0] rd_mux, rdata_q;

  // Address decode
  for (genvar h = 0; h < NH; h++) begin : g_half
    assign cnt_wr[h] = bus_wr && !ctrl_q.run && (bus_addr == AW'(OFS_CNT + 4*h));
    assign cmp_wr[h] = bus_wr && (bus_addr == AW'(OFS_CMP + 4*h));
  end
  assign ctrl_wr = bus_wr && (bus_addr == AW'(OFS_CTRL));
  assign stat_wr = bus_wr && (bus_addr == AW'(OFS_STAT));
  assign step_wr = bus_wr && (bus_addr == AW'(OFS_STEP));
  assign clr     = stat_wr && bus_wdata[0];

  // Control register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.run     <= bus_wdata[CB_RUN];
      ctrl_q.cmp_en  <= bus_wdata[CB_CMP];
      ctrl_q.irq_en  <= bus_wdata[CB_IRQ];
      ctrl_q.auto_en <= bus_wdata[CB_AUTO];
      ctrl_q.presc   <= bus_wdata[PS_LSB +: PS_W];
    end
  end

  gtmr_prescale #(.PS_W(PS_W)) i_presc (
    .clk   (clk),
    .rst   (rst),
    .run   (ctrl_q.run),
    .presc (ctrl_q.presc),
    .tick  (tick)
  );

  gtmr_count #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_count (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .ld      (cnt_wr),
    .ld_data (bus_wdata),
    .cnt     (cnt)
  );

  gtmr_compare #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_cmp (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .cmp_en  (ctrl_q.cmp_en),
    .auto_en (ctrl_q.auto_en),
    .cmp_wr  (cmp_wr),
    .step_wr (step_wr),
    .wdata   (bus_wdata),
    .clr     (clr),
    .cmp     (cmp),
    .step    (step),
    .flag    (flag)
  );

  // Read path
  always_comb begin
    rd_mux = '0;
    for (int h = 0; h < NH; h++) begin
      if (bus_addr == AW'(OFS_CNT + 4*h)) rd_mux = cnt[h*BUS_W +: BUS_W];
      if (bus_addr == AW'(OFS_CMP + 4*h)) rd_mux = cmp[h*BUS_W +: BUS_W];
    end
    if (bus_addr == AW'(OFS_CTRL)) begin
      rd_mux[CB_RUN]            = ctrl_q.run;
      rd_mux[CB_CMP]            = ctrl_q.cmp_en;
      rd_mux[CB_IRQ]            = ctrl_q.irq_en;
      rd_mux[CB_AUTO]           = ctrl_q.auto_en;
      rd_mux[PS_LSB +: PS_W]    = ctrl_q.presc;
    end
    if (bus_addr == AW'(OFS_STAT)) rd_mux[0] = flag;
    if (bus_addr == AW'(OFS_STEP)) rd_mux = step;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq       = flag & ctrl_q.irq_en;

  // R10: read data holds between read strobes
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R4: a counter write while running leaves the lower half on its own course
  a_r4_ignored_running: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ctrl_q.run && !tick && bus_addr == AW'(OFS_CNT)) |=> $stable(cnt));

endmodule

// File: tb/test_gtmr_top.sv
module test_gtmr_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int    n_vec  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  logic  took   = 1'b0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;  // 50 MHz

  gtmr_top i_gtmr_top (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // Monitor: a read strobe seen on an edge is checked at the following negedge
  always @(posedge clk) took <= bus_rd;

  always @(negedge clk) begin
    if (took && q_exp.size() > 0) begin
      logic [31:0] e;
      string       t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_vec++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    bus_addr = a; bus_rd = 1'b1;
    q_exp.push_back(e);
    q_tag.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_vec++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values
    rd(5'h00, 32'h0, "R1 cnt lo");
    rd(5'h04, 32'h0, "R1 cnt hi");
    rd(5'h08, 32'h0, "R1 ctrl");
    rd(5'h0C, 32'h0, "R1 status");
    rd(5'h10, 32'h0, "R1 cmp lo");
    rd(5'h14, 32'h0, "R1 cmp hi");
    rd(5'h18, 32'h0, "R1 step");
    chk_irq(1'b0, "R1 irq");

    // R4: load while stopped
    wr(5'h00, 32'hFFFF_FFFE);
    wr(5'h04, 32'h0000_0005);
    rd(5'h00, 32'hFFFF_FFFE, "R4 load lo");
    rd(5'h04, 32'h0000_0005, "R4 load hi");

    // R3: run with P=0 across the 32-bit rollover
    wr(5'h08, 32'h0000_0001);
    rd(5'h00, 32'hFFFF_FFFE, "R3 lo before wrap");
    rd(5'h04, 32'h0000_0005, "R3 hi one step before wrap");
    rd(5'h00, 32'h0000_0000, "R3 lo after wrap");
    rd(5'h04, 32'h0000_0006, "R3 hi carried");

    // R4: write while running has no effect
    wr(5'h00, 32'h0000_1234);
    rd(5'h00, 32'h0000_0003, "R4 ignored while running");

    // R2: prescaler P=3
    wr(5'h08, 32'h0000_0000);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h08, 32'h0000_0301);
    idle(10);
    rd(5'h00, 32'h0000_0002, "R2 divide by four");
    rd(5'h08, 32'h0000_0301, "R10 ctrl readback");
    wr(5'h08, 32'h0000_0300);
    idle(5);
    rd(5'h00, 32'h0000_0003, "R2 hold when stopped");
    rd(5'h04, 32'h0000_0000, "R2 hi unchanged");

    // R9: compare disabled, counter past comparator
    wr(5'h10, 32'd10);
    wr(5'h14, 32'd0);
    wr(5'h08, 32'h0000_0005);
    idle(20);
    rd(5'h0C, 32'h0, "R9 no event with compare off");
    chk_irq(1'b0, "R9 irq stays low");

    // R5 and R7: enable compare with comparator already passed
    wr(5'h08, 32'h0000_0007);
    idle(2);
    rd(5'h0C, 32'h1, "R5 flag set by past comparator");
    chk_irq(1'b1, "R7 irq with enable");
    wr(5'h08, 32'h0000_0003);
    chk_irq(1'b0, "R7 irq masked");

    // R6: write-one-to-clear
    wr(5'h08, 32'h0000_0001);
    wr(5'h0C, 32'h0);
    rd(5'h0C, 32'h1, "R6 write 0 keeps flag");
    wr(5'h0C, 32'h1);
    rd(5'h0C, 32'h0, "R6 write 1 clears flag");

    // R8: auto-increment
    wr(5'h08, 32'h0);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'd100);
    wr(5'h14, 32'd0);
    wr(5'h18, 32'd50);
    wr(5'h08, 32'h0000_000B);
    idle(120);
    rd(5'h10, 32'd150, "R8 comparator advanced once");
    rd(5'h0C, 32'h1, "R5 flag after periodic event");
    rd(5'h14, 32'd0, "R8 cmp hi unchanged");
    rd(5'h18, 32'd50, "R10 step readback");

    // R8: carry into upper comparator half
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
    wr(5'h00, 32'hFFFF_FFF0);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'hFFFF_FFF0);
    wr(5'h14, 32'h0);
    wr(5'h18, 32'h20);
    wr(5'h08, 32'h0000_000B);
    idle(2);
    rd(5'h14, 32'h1, "R8 carry into cmp hi");
    rd(5'h10, 32'h10, "R8 cmp lo after carry");
    chk_irq(1'b0, "R7 irq low with enable clear");

    idle(3);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

endmodule